// File: doc/BRIEF.md
# MAC Address Hash Table Engine

This block keeps an on-chip filter table of 48-bit MAC addresses and answers add, delete, lookup and clear commands issued one at a time. A request carries the address as a 16-bit upper part and a 32-bit lower part, together with two attribute bits (skip and receive-discard). The block folds the address into an 11-bit slot index and then walks forward from that slot, one slot per clock, wrapping from the top of the table to slot 0. The walk stops at the first free slot or the first slot holding the same address. It gives up after a fixed number of slots.

Each slot is a 64-bit word: a lower word and an upper word. The 48 address bits are spread over both words in a nibble-permuted order. The lower word also holds a valid flag and the two attributes. When a command finishes, the block gives a one-cycle done pulse with found and full flags, the slot index it settled on and, for a successful lookup, the stored attributes. A clear command writes zero into every slot, one slot per clock.

Top module: `mac_hash_table`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done` is 0.
- R2: Byte-reverse every byte of both address parts. Call the 32-bit result L and the 16-bit result H. The start slot is bits 10:0 of ({L[7:2]} << 9) OR ({L[14:8],L[1:0]} XOR L[23:15] XOR {H[0],L[31:24]}). An add into an empty region reports this slot in `rsp_index`.
- R3: The walk moves up by one slot per step, and slot 2047 is followed by slot 0. An add whose start slot is taken by a different address lands in the next free slot.
- R4: An add of an address already present in the walk window overwrites that same slot. It reports `rsp_found`=1 and the new attributes replace the old ones.
- R5: If HOPS (default 12) slots are checked and none is free or matching, an add reports `rsp_full`=1 and `rsp_found`=0. Nothing is written, so a later lookup of that address is not found.
- R6: A delete that finds its address reports `rsp_found`=1 and that slot's index, and zeroes the slot. A walk stops at the first free slot, so entries placed beyond a deleted slot in the same chain are no longer found.
- R7: A delete whose address is absent reports `rsp_found`=0 and changes no stored entry.
- R8: A lookup reports `rsp_found`=1 only for a valid matching slot inside the window, together with its index, `rsp_skip` and `rsp_discard`. Otherwise all three flags are 0, and a lookup never writes the table.
- R9: A clear makes every slot free. Lookups afterwards miss, and adds go back to their start slots.
- R10: Command codes on `req_op`: 0 lookup, 1 add, 2 delete, 3 clear. Handshake: a command is taken when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the command completes. `rsp_done` lasts one cycle.
- R11: A command accepted in the same cycle as the previous command's `rsp_done` sees the table as that command left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block idle, command is taken this cycle |
| req_op | input | 2 | 0 lookup, 1 add, 2 delete, 3 clear |
| req_mac_hi | input | 16 | Upper 16 address bits |
| req_mac_lo | input | 32 | Lower 32 address bits |
| req_skip | input | 1 | Skip attribute stored on add |
| req_discard | input | 1 | Receive-discard attribute stored on add |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_found | output | 1 | A valid matching slot was met |
| rsp_full | output | 1 | Add failed, window exhausted |
| rsp_index | output | 11 | Slot the walk ended on |
| rsp_skip | output | 1 | Stored skip bit (lookup hit) |
| rsp_discard | output | 1 | Stored discard bit (lookup hit) |

## Verification
Two events can land in the same cycle: the completion pulse of one command and the acceptance of the next. The table read for the new command is then issued in the cycle right after the old command's write. The bench provokes this by raising the next request as soon as it has handed over the previous one, so each command is accepted on the previous command's done cycle. Lookups that follow adds and deletes this closely must see the fresh contents, and the bench counts and checks how often the overlap occurred.

// File: rtl/mht_pkg.sv
package mht_pkg;
  localparam int IDX_W  = 11;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_ADD    = 2'd1,
    OP_DEL    = 2'd2,
    OP_CLEAR  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_WIPE  = 2'd2
  } state_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } slot_t;
endpackage

// File: rtl/mht_hash.sv
module mht_hash
  import mht_pkg::*;
(
  input  logic [15:0]      mac_hi,
  input  logic [31:0]      mac_lo,
  input  logic             skip,
  input  logic             discard,
  output logic [IDX_W-1:0] idx,
  output slot_t            key
);
  logic [31:0] l_rev;
  logic [15:0] h_rev;

  // every byte mirrored in place
  for (genvar b = 0; b < 4; b++) begin : g_lo_byte
    for (genvar k = 0; k < 8; k++) begin : g_lo_bit
      assign l_rev[b*8+k] = mac_lo[b*8+7-k];
    end
  end
  for (genvar b = 0; b < 2; b++) begin : g_hi_byte
    for (genvar k = 0; k < 8; k++) begin : g_hi_bit
      assign h_rev[b*8+k] = mac_hi[b*8+7-k];
    end
  end

  logic [5:0]  part0;
  logic [8:0]  part1, part2, part3;
  logic [14:0] folded;

  always_comb begin
    part0  = l_rev[7:2];
    part1  = {l_rev[14:8], l_rev[1:0]};
    part2  = l_rev[23:15];
    part3  = {h_rev[0], l_rev[31:24]};
    folded = {part0, 9'd0} | {6'd0, part1 ^ part2 ^ part3};
    idx    = folded[IDX_W-1:0];
  end

  always_comb begin
    key.lo = {mac_lo[20], mac_lo[19:16], mac_lo[31:28], mac_lo[27:24],
              mac_hi[7:4], mac_hi[3:0], mac_hi[15:12], mac_hi[11:8],
              discard, skip, 1'b1};
    key.hi = {13'd0, mac_lo[7:4], mac_lo[3:0], mac_lo[15:12], mac_lo[11:8],
              mac_lo[23:21]};
  end
endmodule

// File: rtl/mht_ram.sv
module mht_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    we |-> !$isunknown(waddr)); // R6
endmodule

// File: rtl/mac_hash_table.sv
module mac_hash_table
  import mht_pkg::*;
#(
  parameter int HOPS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_mac_hi,
  input  logic [31:0]      req_mac_lo,
  input  logic             req_skip,
  input  logic             req_discard,
  output logic             rsp_done,
  output logic             rsp_found,
  output logic             rsp_full,
  output logic [IDX_W-1:0] rsp_index,
  output logic             rsp_skip,
  output logic             rsp_discard
);
  localparam int HOP_W  = $clog2(HOPS + 1);
  localparam int SLOT_W = 2 * WORD_W;

  state_e           state;
  op_e              op_q;
  slot_t            key_q;
  logic [IDX_W-1:0] pos_q;
  logic [HOP_W-1:0] hop_q;
  logic [IDX_W-1:0] wipe_q;

  logic [IDX_W-1:0] req_idx;
  slot_t            req_key;
  slot_t            cur;
  logic [SLOT_W-1:0] rd_raw;

  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  slot_t            wr_slot;
  logic [IDX_W-1:0] rd_addr;

  logic cur_valid, cur_match, hit, stop_here, window_end;

  mht_hash u_hash (
    .mac_hi  (req_mac_hi),
    .mac_lo  (req_mac_lo),
    .skip    (req_skip),
    .discard (req_discard),
    .idx     (req_idx),
    .key     (req_key)
  );

  mht_ram #(.ADDR_W(IDX_W), .DATA_W(SLOT_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_slot),
    .raddr (rd_addr),
    .rdata (rd_raw)
  );

  assign cur       = slot_t'(rd_raw);
  assign req_ready = (state == ST_IDLE);

  always_comb begin
    cur_valid  = cur.lo[0];
    cur_match  = (cur.lo[WORD_W-1:3] == key_q.lo[WORD_W-1:3]) && (cur.hi == key_q.hi);
    hit        = cur_valid && cur_match;
    stop_here  = !cur_valid || cur_match;
    window_end = (hop_q == HOP_W'(HOPS - 1));
  end

  // read port: start slot while idle, next slot while walking
  always_comb begin
    if (state == ST_IDLE) rd_addr = req_idx;
    else                  rd_addr = pos_q + 1'b1;
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = pos_q;
    wr_slot = '0;
    case (state)
      ST_PROBE: begin
        if (op_q == OP_ADD && stop_here) begin
          wr_en   = 1'b1;
          wr_slot = key_q;
        end else if (op_q == OP_DEL && hit) begin
          wr_en = 1'b1;
        end
      end
      ST_WIPE: begin
        wr_en   = 1'b1;
        wr_addr = wipe_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_LOOKUP;
      key_q       <= '0;
      pos_q       <= '0;
      hop_q       <= '0;
      wipe_q      <= '0;
      rsp_done    <= 1'b0;
      rsp_found   <= 1'b0;
      rsp_full    <= 1'b0;
      rsp_index   <= '0;
      rsp_skip    <= 1'b0;
      rsp_discard <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q  <= op_e'(req_op);
            key_q <= req_key;
            pos_q <= req_idx;
            hop_q <= '0;
            if (op_e'(req_op) == OP_CLEAR) begin
              wipe_q <= '0;
              state  <= ST_WIPE;
            end else begin
              state <= ST_PROBE;
            end
          end
        end
        ST_PROBE: begin
          if (stop_here || window_end) begin
            state       <= ST_IDLE;
            rsp_done    <= 1'b1;
            rsp_found   <= hit;
            rsp_full    <= (op_q == OP_ADD) && !stop_here;
            rsp_index   <= pos_q;
            rsp_skip    <= (op_q == OP_LOOKUP) && hit && cur.lo[1];
            rsp_discard <= (op_q == OP_LOOKUP) && hit && cur.lo[2];
          end else begin
            pos_q <= pos_q + 1'b1;
            hop_q <= hop_q + 1'b1;
          end
        end
        ST_WIPE: begin
          wipe_q <= wipe_q + 1'b1;
          if (&wipe_q) begin
            state       <= ST_IDLE;
            rsp_done    <= 1'b1;
            rsp_found   <= 1'b0;
            rsp_full    <= 1'b0;
            rsp_index   <= '0;
            rsp_skip    <= 1'b0;
            rsp_discard <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R10
  AST_FULL_ONLY_ADD: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_full) |-> (op_q == OP_ADD)); // R5
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_full) |-> !$past(wr_en)); // R5
  AST_FULL_NOT_FOUND: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !(rsp_full && rsp_found)); // R5
  AST_HOP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROBE) |-> (int'(hop_q) < HOPS)); // R3
  AST_LOOKUP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROBE && op_q == OP_LOOKUP) |-> !wr_en); // R8
endmodule

// File: tb/tb_mac_hash_table.sv
module tb_mac_hash_table;
  localparam int HOPS = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_mac_hi = '0;
  logic [31:0] req_mac_lo = '0;
  logic        req_skip = 1'b0;
  logic        req_discard = 1'b0;
  logic        rsp_done, rsp_found, rsp_full, rsp_skip, rsp_discard;
  logic [10:0] rsp_index;

  always #10 clk = ~clk;

  mac_hash_table #(.HOPS(HOPS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mac_hi(req_mac_hi), .req_mac_lo(req_mac_lo),
    .req_skip(req_skip), .req_discard(req_discard), .rsp_done(rsp_done),
    .rsp_found(rsp_found), .rsp_full(rsp_full), .rsp_index(rsp_index),
    .rsp_skip(rsp_skip), .rsp_discard(rsp_discard)
  );

  typedef struct {
    logic        found;
    logic        full;
    logic [10:0] idx;
    logic        chk_idx;
    logic        skip;
    logic        disc;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  int overlap = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [10:0] model_hash(input logic [15:0] hi, input logic [31:0] lo);
    logic [31:0] l;
    logic [15:0] h;
    logic [14:0] v;
    l = {rev8(lo[31:24]), rev8(lo[23:16]), rev8(lo[15:8]), rev8(lo[7:0])};
    h = {rev8(hi[15:8]), rev8(hi[7:0])};
    v = ({9'd0, l[7:2]} << 9) | {6'd0, ({l[14:8], l[1:0]} ^ l[23:15] ^ {h[0], l[31:24]})};
    return v[10:0];
  endfunction

  function automatic logic [31:0] find_lo(input logic [31:0] seed, input int lo_b, input int hi_b);
    logic [31:0] c;
    int h;
    c = seed;
    for (int i = 0; i < 200000; i++) begin
      h = int'(model_hash(16'h0000, c));
      if (h >= lo_b && h <= hi_b) return c;
      c = c + 32'h0001_0203;
    end
    return seed;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (sbq.size() == 0) begin
        check(0, "R10 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(rsp_found == e.found, {e.tag, " found"}, rsp_found, e.found);
        check(rsp_full == e.full, {e.tag, " full"}, rsp_full, e.full);
        if (e.chk_idx) check(rsp_index == e.idx, {e.tag, " index"}, rsp_index, e.idx);
        check(rsp_skip == e.skip && rsp_discard == e.disc, {e.tag, " attrs"},
              {rsp_discard, rsp_skip}, {e.disc, e.skip});
      end
    end
  end

  task automatic drive(input logic [1:0] op, input logic [15:0] hi, input logic [31:0] lo,
                       input logic sk, input logic dc, input logic ef, input logic efl,
                       input logic [10:0] ei, input logic ci, input logic es, input logic ed,
                       input string tag);
    exp_t e;
    e.found = ef; e.full = efl; e.idx = ei; e.chk_idx = ci;
    e.skip = es; e.disc = ed; e.tag = tag;
    sbq.push_back(e);
    req_op = op; req_mac_hi = hi; req_mac_lo = lo;
    req_skip = sk; req_discard = dc; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (rsp_done) overlap++;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {"R10 busy after accept ", tag}, req_ready, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0 pending", sbq.size());
    finish_run();
  end

  initial begin
    logic [31:0] lo1, lo2, lo3, low;
    logic [10:0] h1, h2, h3b, h3a;
    lo1 = find_lo(32'h1234_5678, 100, 300);
    lo2 = find_lo(32'h9abc_def0, 600, 800);
    lo3 = find_lo(32'h0f1e_2d3c, 1200, 1400);
    low = find_lo(32'h5566_7788, 2047, 2047);
    h1 = model_hash(16'h0000, lo1);
    h2 = model_hash(16'h0000, lo2);
    h3b = model_hash(16'h0080, lo3);
    h3a = model_hash(16'h0000, lo3);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_done == 1'b0, "R1 done after reset", rsp_done, 0);
    check(h3a != h3b, "R2 upper byte bit reaches index", h3a, h3b);

    drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 initial clear");
    drive(2'd1, 16'h0000, lo1, 0, 0, 0, 0, h1, 1, 0, 0, "R2 add A start slot");
    drive(2'd1, 16'h0001, lo1, 0, 0, 0, 0, h1 + 11'd1, 1, 0, 0, "R3 add B next slot");
    drive(2'd1, 16'h0002, lo1, 0, 0, 0, 0, h1 + 11'd2, 1, 0, 0, "R3 add C third slot");
    drive(2'd1, 16'h0000, lo1, 1, 1, 1, 0, h1, 1, 0, 0, "R4 re-add A overwrites");
    drive(2'd0, 16'h0000, lo1, 0, 0, 1, 0, h1, 1, 1, 1, "R8 R11 lookup A attrs");
    drive(2'd0, 16'h0001, lo1, 0, 0, 1, 0, h1 + 11'd1, 1, 0, 0, "R8 lookup B");
    drive(2'd1, 16'h0080, lo3, 0, 1, 0, 0, h3b, 1, 0, 0, "R2 add D start slot");

    for (int k = 0; k < HOPS; k++)
      drive(2'd1, 16'h0010 + 16'(k), lo2, 0, 0, 0, 0, h2 + 11'(k), 1, 0, 0, "R3 fill window");
    drive(2'd1, 16'h0010 + 16'(HOPS), lo2, 0, 0, 0, 1, 0, 0, 0, 0, "R5 add into full window");
    drive(2'd0, 16'h0010 + 16'(HOPS), lo2, 0, 0, 0, 0, 0, 0, 0, 0, "R5 failed add not stored");
    drive(2'd0, 16'h0010 + 16'(HOPS-1), lo2, 0, 0, 1, 0, h2 + 11'(HOPS-1), 1, 0, 0, "R8 lookup last in window");

    drive(2'd2, 16'h0001, lo1, 0, 0, 1, 0, h1 + 11'd1, 1, 0, 0, "R6 delete B");
    drive(2'd0, 16'h0001, lo1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 B gone");
    drive(2'd0, 16'h0002, lo1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 C hidden behind free slot");
    drive(2'd2, 16'h0050, lo3, 0, 0, 0, 0, 0, 0, 0, 0, "R7 delete absent");
    drive(2'd0, 16'h0080, lo3, 0, 0, 1, 0, h3b, 1, 0, 1, "R7 D kept");
    drive(2'd0, 16'h0000, lo1, 0, 0, 1, 0, h1, 1, 1, 1, "R7 A kept");

    drive(2'd1, 16'h0000, low, 0, 0, 0, 0, 11'd2047, 1, 0, 0, "R3 add at top slot");
    drive(2'd1, 16'h0001, low, 0, 0, 0, 0, 11'd0, 1, 0, 0, "R3 wrap to slot 0");
    drive(2'd0, 16'h0001, low, 0, 0, 1, 0, 11'd0, 1, 0, 0, "R3 lookup wrapped");

    drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 clear");
    drive(2'd0, 16'h0000, lo1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 A cleared");
    drive(2'd0, 16'h0001, low, 0, 0, 0, 0, 0, 0, 0, 0, "R9 wrapped cleared");
    drive(2'd1, 16'h0010 + 16'(HOPS), lo2, 0, 0, 0, 0, h2, 1, 0, 0, "R9 add after clear at start");

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    check(overlap > 0, "R11 acceptance coincided with done", overlap, 1);
    finish_run();
  end
endmodule